// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Synthesizer

This block generates a digital sine carrier for a frequency-shift-keyed transmitter. Two 16-bit step words are held in the block, one for the space tone and one for the mark tone. While a burst runs, a transmit-data bit picks one of the two words on every clock. The picked word is added to an 18-bit phase accumulator. The upper ten accumulator bits address a quarter-wave sine table, and mirroring that table gives a signed 12-bit sample.

Every clock cycle is one synthesis update. A tone of frequency f needs the step value round(2^18 · f / f_clk). A burst always begins at phase zero, so its first sample is 0. A change of data bit keeps the accumulated phase. When transmit enable drops, the generator runs on until the accumulator wraps, which completes the sine period in progress, and then goes idle. In idle the accumulator is held at zero and the sample is 0.

Top module: `fsk_tone_synth`

## Requirements
- R1: After reset both step words are 0, the generator is idle, sample_valid is 0 and sample_out is 0.
- R2: A write with wr_en=1 loads wr_data into the space word when wr_sel=0, or into the mark word when wr_sel=1. The new value is first used at the accumulator update one clock after the write.
- R3: While active, on each clock the accumulator (18 bits, wrapping) adds the mark word when tx_bit=1 or the space word when tx_bit=0.
- R4: While active, sample_out equals s·round(2047·|sin(2π·p/1024)|), where p is accumulator bits 17:8 and s is the sign of the sine.
- R5: A clock edge that sees tx_en=1 while idle starts a burst with the accumulator at 0. The first valid sample is therefore 0.
- R6: Changing tx_bit during a burst does not reset or jump the phase; only the added step changes.
- R7: On the first clock with tx_en=0 during a burst, the generator goes idle at once if the accumulator is 0. Otherwise it keeps adding steps. It goes idle, with the accumulator at 0, on the update that carries past 2^18.
- R8: While idle, sample_valid is 0 and sample_out is 0. Neither tx_bit nor step-word writes change them.
- R9: While the generator finishes a period, tx_en=1 is ignored. A new burst can start only after the generator is idle again.
- R10: With step value N, one output period lasts 2^18/N clocks. For N=4096 the sample is 2047 sixteen updates after the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; each rising edge is one synthesis update |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Step-word write strobe |
| wr_sel | input | 1 | Write target: 0 space word, 1 mark word |
| wr_data | input | 16 | Step value to store |
| tx_en | input | 1 | Transmit enable |
| tx_bit | input | 1 | Data bit: 1 selects mark, 0 selects space |
| sample_out | output | 12 | Signed sine sample |
| sample_valid | output | 1 | High while a burst or its closing period is active |

## Verification
The assertions assume that all inputs are known and stable around each rising edge, and that reset is applied before the first update. The drain-related properties also assume the step in use is nonzero while a period is being finished; with a zero step the wrap that ends the period would never come. The stimulus changes inputs just after each edge, holds reset high from time zero, and loads nonzero step words before any burst is ended. The only exception is the zero-step burst right after reset. That burst is ended while its accumulator is still 0, so it goes idle at once.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
    localparam int ACC_W   = 18;
    localparam int STEP_W  = 16;
    localparam int ADDR_W  = 10;
    localparam int SAMP_W  = 12;
    localparam int QIDX_W  = ADDR_W - 2;
    localparam int QLEN    = 1 << QIDX_W;
    localparam int AMP     = (1 << (SAMP_W - 1)) - 1;

    typedef logic [ACC_W-1:0]  phase_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic signed [SAMP_W-1:0] samp_t;

    typedef enum logic [1:0] {
        GEN_IDLE  = 2'd0,
        GEN_RUN   = 2'd1,
        GEN_DRAIN = 2'd2
    } gen_state_e;

    typedef struct packed {
        logic [1:0]        quad;
        logic [QIDX_W-1:0] idx;
    } lut_addr_t;

    function automatic int qsine(input int i);
        real x;
        x = $itor(AMP) * $sin(2.0 * 3.14159265358979 * $itor(i) / $itor(4 * QLEN));
        return int'($floor(x + 0.5));
    endfunction
endpackage

// File: rtl/fsk_step_bank.sv
module fsk_step_bank
    import fsk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic  wr_sel,
    input  step_t wr_data,
    input  logic  tx_bit,
    output step_t step_sel
);
    step_t space_q;
    step_t mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            space_q <= '0;
            mark_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel) mark_q  <= wr_data;
            else        space_q <= wr_data;
        end
    end

    assign step_sel = tx_bit ? mark_q : space_q;

    a_r2_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(space_q) && $stable(mark_q)));
endmodule

// File: rtl/fsk_phase_ctrl.sv
module fsk_phase_ctrl
    import fsk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   tx_en,
    input  step_t  step,
    output phase_t acc,
    output logic   active
);
    localparam int PAD_W = ACC_W - STEP_W + 1;

    gen_state_e state_q, state_d;
    phase_t acc_q, acc_d;
    logic [ACC_W:0] sum;
    logic carry;

    assign sum   = {1'b0, acc_q} + {{PAD_W{1'b0}}, step};
    assign carry = sum[ACC_W];

    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        unique case (state_q)
            GEN_IDLE: begin
                acc_d = '0;
                if (tx_en) state_d = GEN_RUN;
            end
            GEN_RUN: begin
                if (tx_en) begin
                    acc_d = sum[ACC_W-1:0];
                end else if (acc_q == '0 || carry) begin
                    state_d = GEN_IDLE;
                    acc_d   = '0;
                end else begin
                    state_d = GEN_DRAIN;
                    acc_d   = sum[ACC_W-1:0];
                end
            end
            GEN_DRAIN: begin
                if (carry) begin
                    state_d = GEN_IDLE;
                    acc_d   = '0;
                end else begin
                    acc_d = sum[ACC_W-1:0];
                end
            end
            default: begin
                state_d = GEN_IDLE;
                acc_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GEN_IDLE;
            acc_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
        end
    end

    assign acc    = acc_q;
    assign active = (state_q != GEN_IDLE);

    a_r5_start_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_IDLE && tx_en) |=> (acc_q == '0 && state_q == GEN_RUN));
    a_r3_advance: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_RUN && tx_en) |=> (acc_q == ACC_W'($past(acc_q) + ACC_W'($past(step)))));
    a_r9_no_restart_in_drain: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_DRAIN) |=> (state_q != GEN_RUN));
    a_r7_idle_at_zero: assert property (@(posedge clk) disable iff (rst)
        (state_q == GEN_IDLE) |-> (acc_q == '0));
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
    import fsk_pkg::*;
(
    input  lut_addr_t addr,
    output samp_t     sample
);
    logic [SAMP_W-2:0] quarter [QLEN];

    for (genvar i = 0; i < QLEN; i++) begin : g_tab
        localparam int VAL = qsine(i);
        assign quarter[i] = (SAMP_W-1)'(VAL);
    end

    logic [QIDX_W-1:0] mirror_idx;
    logic [SAMP_W-2:0] mag;
    logic              use_peak;

    assign mirror_idx = QIDX_W'(QLEN - int'(addr.idx));
    assign use_peak   = addr.quad[0] && (addr.idx == '0);

    always_comb begin
        if (use_peak)          mag = (SAMP_W-1)'(AMP);
        else if (addr.quad[0]) mag = quarter[mirror_idx];
        else                   mag = quarter[addr.idx];
    end

    assign sample = addr.quad[1] ? -samp_t'({1'b0, mag}) : samp_t'({1'b0, mag});

    always_comb begin
        a_r4_zero_at_axis: assert (!(addr.quad[0] == 1'b0 && addr.idx == '0) || sample == '0);
    end
endmodule

// File: rtl/fsk_tone_synth.sv
module fsk_tone_synth
    import fsk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [15:0]       wr_data,
    input  logic              tx_en,
    input  logic              tx_bit,
    output logic signed [11:0] sample_out,
    output logic              sample_valid
);
    step_t     step;
    phase_t    acc;
    logic      active;
    lut_addr_t addr;

    fsk_step_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .tx_bit   (tx_bit),
        .step_sel (step)
    );

    fsk_phase_ctrl u_phase (
        .clk    (clk),
        .rst    (rst),
        .tx_en  (tx_en),
        .step   (step),
        .acc    (acc),
        .active (active)
    );

    assign addr = lut_addr_t'(acc[ACC_W-1 -: ADDR_W]);

    fsk_sine_lut u_lut (
        .addr   (addr),
        .sample (sample_out)
    );

    assign sample_valid = active;

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> (sample_out == '0));
    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> !sample_valid);
endmodule

// File: tb/sim_fsk_tone_synth.sv
module sim_fsk_tone_synth;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, wr_sel = 1'b0, tx_en = 1'b0, tx_bit = 1'b0;
    logic [15:0] wr_data = '0;
    logic signed [11:0] sample_out;
    logic sample_valid;

    int n_chk = 0;
    int n_bad = 0;

    int m_state = 0;
    int m_acc   = 0;
    int m_space = 0;
    int m_mark  = 0;

    always #10 clk = ~clk;

    fsk_tone_synth u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .tx_en(tx_en), .tx_bit(tx_bit), .sample_out(sample_out), .sample_valid(sample_valid)
    );

    function automatic int exp_sample(input int acc);
        int p;
        real x;
        int mag;
        p = acc >> 8;
        x = 2047.0 * $sin(2.0 * 3.14159265358979 * $itor(p) / 1024.0);
        mag = int'($floor((x < 0.0 ? -x : x) + 0.5));
        return (x < 0.0) ? -mag : mag;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(input logic en, input logic b, input logic we, input logic sel, input int d);
        int stp;
        int sum;
        stp = b ? m_mark : m_space;
        sum = m_acc + stp;
        case (m_state)
            0: if (en) begin m_state = 1; m_acc = 0; end
            1: begin
                if (en) m_acc = sum % 262144;
                else if (m_acc == 0 || sum >= 262144) begin m_state = 0; m_acc = 0; end
                else begin m_state = 2; m_acc = sum; end
            end
            default: begin
                if (sum >= 262144) begin m_state = 0; m_acc = 0; end
                else m_acc = sum;
            end
        endcase
        if (we) begin
            if (sel) m_mark = d; else m_space = d;
        end
    endtask

    task automatic cyc(input logic en, input logic b, input logic we, input logic sel,
                       input int d, input string tag);
        tx_en = en; tx_bit = b; wr_en = we; wr_sel = sel; wr_data = 16'(d);
        @(posedge clk);
        model_edge(en, b, we, sel, d);
        #5;
        check({tag, " valid"}, int'(sample_valid), (m_state != 0) ? 1 : 0);
        check({tag, " sample"}, int'(sample_out), (m_state != 0) ? exp_sample(m_acc) : 0);
    endtask

    task automatic write_step(input logic sel, input int d);
        cyc(tx_en, tx_bit, 1'b1, sel, d, "R2 write");
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #5;
        check("R1 valid after reset", int'(sample_valid), 0);
        check("R1 sample after reset", int'(sample_out), 0);
        for (int i = 0; i < 4; i++) cyc(1'b1, i[0], 1'b0, 1'b0, 0, "R1 zero steps");
        check("R1 steps zero keep phase", int'(sample_out), 0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 leave at zero");
        check("R7 immediate idle", int'(sample_valid), 0);
    endtask

    task automatic t_space_tone;
        write_step(1'b0, 4096);
        write_step(1'b1, 8192);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R5 start");
        check("R5 first sample zero", int'(sample_out), 0);
        for (int i = 1; i <= 70; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 R4 space");
            if (i == 16) check("R10 peak at 16", int'(sample_out), 2047);
            if (i == 48) check("R10 trough at 48", int'(sample_out), -2047);
            if (i == 64) check("R10 period 64", int'(sample_out), 0);
        end
    endtask

    task automatic t_switch;
        write_step(1'b1, 5003);
        for (int i = 0; i < 60; i++)
            cyc(1'b1, (i % 7) < 3, 1'b0, 1'b0, 0, "R6 switch");
    endtask

    task automatic t_write_midburst;
        cyc(1'b1, 1'b0, 1'b1, 1'b0, 1234, "R2 write live");
        for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R2 new space");
    endtask

    task automatic t_drain;
        int n;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 0, "R7 fall");
        n = 0;
        while (m_state != 0 && n < 300) begin
            cyc(1'b1, n[0], 1'b0, 1'b0, 0, "R9 drain ignores en");
            n++;
        end
        check("R7 ends idle", int'(sample_valid), 0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R9 restart");
        check("R9 restart at zero", int'(sample_out), 0);
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 after restart");
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 fall 2");
        n = 0;
        while (m_state != 0 && n < 300) begin
            cyc(1'b0, 1'b0, 1'b0, 1'b0, 0, "R7 drain");
            n++;
        end
        check("R7 idle after wrap", int'(sample_valid), 0);
    endtask

    task automatic t_idle;
        for (int i = 0; i < 8; i++) cyc(1'b0, i[0], i[1], i[2], 777 * i, "R8 idle");
        check("R8 idle sample", int'(sample_out), 0);
        check("R8 idle valid", int'(sample_valid), 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_space_tone();
                t_switch();
                t_write_midburst();
                t_drain();
                t_idle();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule